// File: doc/BRIEF.md
# ECC Error Capture and Status Unit

This unit sits beside the ECC checker of a DRAM controller and logs the errors the checker reports. Each correctable or uncorrectable error arrives as a one-cycle pulse. The pulse carries the failing physical address, an 8-bit syndrome and a bit that names which of two channels saw the fault. The unit keeps a sticky flag for each error class. It also keeps one captured record: a 4 KiB block address, the syndrome and the channel.

Software reads and writes the unit through a simple word-addressed register port, and reads return data in the same cycle. Software clears a flag by writing one to its bit. A command register enables an error-signal output separately for each class. The record holds whichever error matters most. An uncorrectable error replaces a correctable record that has already been taken. No later correctable error can disturb a captured uncorrectable one.

Top module: `ecc_err_capture`

## Requirements
- R1: After reset every register reads zero and `err_signal` is low.
- R2: A `ce_valid` pulse sets status bit 0 and a `ue_valid` pulse sets status bit 7. Each flag stays set until software clears it.
- R3: With no flag set, an error captures the failing address. The address register (offset 2) returns address bits 31:12 in its bits 31:12 and zero in bits 11:0. The syndrome register (offset 3) returns the syndrome in bits 7:0, and the location register (offset 4) returns the channel in bit 0.
- R4: A `ue_valid` pulse while the uncorrectable flag is clear captures its own address, syndrome and channel, even when a correctable record is already held. When both pulses come in the same cycle, the uncorrectable data is taken and both flags set.
- R5: While any flag is set, a correctable error leaves the captured fields unchanged. While the uncorrectable flag is set, a further uncorrectable error also leaves them unchanged.
- R6: Writing one to status bit 0 or bit 7 (offset 0) clears that flag. Writing zero to a flag bit leaves it as it was.
- R7: If an error arrives in the same cycle as a write that clears its flag, the flag stays set.
- R8: In the command register (offset 1), bit 7 enables signalling for correctable errors and bit 8 for uncorrectable errors. `err_signal` is high exactly while some set flag has its enable bit set.
- R9: Reserved bits of the status and command registers read zero and ignore writes. The address, syndrome and location registers are read-only, and offsets 5 to 7 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_valid | input | 1 | Correctable error pulse |
| ue_valid | input | 1 | Uncorrectable error pulse |
| err_addr | input | ADDR_W | Failing physical address |
| err_syn | input | SYN_W | ECC syndrome of the error |
| err_chan | input | 1 | Channel that reported the error |
| reg_addr | input | 3 | Register word offset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, same cycle |
| err_signal | output | 1 | Enabled error indication |

## Verification
The assertions check on every cycle that flags are sticky, that an error overrides a clear in the same cycle, and that the record stays frozen while an uncorrectable error is held. They also check that a first uncorrectable error lands in the record and that an enabled flag drives `err_signal`. Only the bench scenarios show the register map as software sees it. That covers the bit positions, zeroed low address bits, reserved and read-only bits, and the exact record held after sequences of correctable, uncorrectable and simultaneous errors.

// File: rtl/ecc_err_capture.sv
module ecc_err_capture #(
  parameter int ADDR_W   = 32,
  parameter int SYN_W    = 8,
  parameter int PAGE_LSB = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_valid,
  input  logic              ue_valid,
  input  logic [ADDR_W-1:0] err_addr,
  input  logic [SYN_W-1:0]  err_syn,
  input  logic              err_chan,
  input  logic [2:0]        reg_addr,
  input  logic              reg_wr_en,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              err_signal
);
  localparam int BLK_W = ADDR_W - PAGE_LSB;
  localparam logic [2:0] OFS_STAT = 3'd0;
  localparam logic [2:0] OFS_CMD  = 3'd1;
  localparam logic [2:0] OFS_ADDR = 3'd2;
  localparam logic [2:0] OFS_SYN  = 3'd3;
  localparam logic [2:0] OFS_LOC  = 3'd4;
  localparam int CE_BIT = 0;
  localparam int UE_BIT = 7;
  localparam int CE_EN  = 7;
  localparam int UE_EN  = 8;

  logic             ce_q, ue_q, en_ce_q, en_ue_q, chan_q;
  logic [BLK_W-1:0] blk_q;
  logic [SYN_W-1:0] syn_q;

  logic stat_wr, cmd_wr, take_ue, take_ce, take;
  assign stat_wr = reg_wr_en && (reg_addr == OFS_STAT);
  assign cmd_wr  = reg_wr_en && (reg_addr == OFS_CMD);
  assign take_ue = ue_valid && !ue_q;
  assign take_ce = ce_valid && !ue_valid && !ce_q && !ue_q;
  assign take    = take_ue || take_ce;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ce_q    <= 1'b0;
      ue_q    <= 1'b0;
      en_ce_q <= 1'b0;
      en_ue_q <= 1'b0;
      chan_q  <= 1'b0;
      blk_q   <= '0;
      syn_q   <= '0;
    end else begin
      ce_q <= ce_valid || (ce_q && !(stat_wr && reg_wdata[CE_BIT]));
      ue_q <= ue_valid || (ue_q && !(stat_wr && reg_wdata[UE_BIT]));
      if (cmd_wr) begin
        en_ce_q <= reg_wdata[CE_EN];
        en_ue_q <= reg_wdata[UE_EN];
      end
      if (take) begin
        blk_q  <= err_addr[ADDR_W-1:PAGE_LSB];
        syn_q  <= err_syn;
        chan_q <= err_chan;
      end
    end
  end

  assign err_signal = (ce_q && en_ce_q) || (ue_q && en_ue_q);

  logic [31:0] addr_rd, stat_rd, cmd_rd;
  always_comb begin
    addr_rd = '0;
    addr_rd[ADDR_W-1:PAGE_LSB] = blk_q;
    stat_rd = '0;
    stat_rd[CE_BIT] = ce_q;
    stat_rd[UE_BIT] = ue_q;
    cmd_rd = '0;
    cmd_rd[CE_EN] = en_ce_q;
    cmd_rd[UE_EN] = en_ue_q;
  end

  always_comb begin
    case (reg_addr)
      OFS_STAT: reg_rdata = stat_rd;
      OFS_CMD:  reg_rdata = cmd_rd;
      OFS_ADDR: reg_rdata = addr_rd;
      OFS_SYN:  reg_rdata = 32'(syn_q);
      OFS_LOC:  reg_rdata = {31'd0, chan_q};
      default:  reg_rdata = '0;
    endcase
  end

  logic unused_bits;
  assign unused_bits = ^{reg_wdata[31:9], reg_wdata[6:1], err_addr[PAGE_LSB-1:0]};
endmodule

module ecc_err_capture_chk #(
  parameter int BLK_W = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ce_valid,
  input logic             ue_valid,
  input logic [BLK_W-1:0] new_blk,
  input logic             reg_wr_en,
  input logic [2:0]       reg_addr,
  input logic [31:0]      reg_wdata,
  input logic             ce_q,
  input logic             ue_q,
  input logic             en_ce_q,
  input logic             en_ue_q,
  input logic [BLK_W-1:0] blk_q,
  input logic             err_signal
);
  logic clr_ce, clr_ue;
  assign clr_ce = reg_wr_en && reg_addr == 3'd0 && reg_wdata[0];
  assign clr_ue = reg_wr_en && reg_addr == 3'd0 && reg_wdata[7];

  p_ce_set_r2: assert property (@(posedge clk) disable iff (!rst_n) ce_valid |=> ce_q);
  p_ue_set_r2: assert property (@(posedge clk) disable iff (!rst_n) ue_valid |=> ue_q);
  p_ce_hold_r6: assert property (@(posedge clk) disable iff (!rst_n) (ce_q && !clr_ce) |=> ce_q);
  p_ue_hold_r6: assert property (@(posedge clk) disable iff (!rst_n) (ue_q && !clr_ue) |=> ue_q);
  p_clr_win_r7: assert property (@(posedge clk) disable iff (!rst_n) (ce_valid && clr_ce) |=> ce_q);
  p_ue_capture_r4: assert property (@(posedge clk) disable iff (!rst_n) (ue_valid && !ue_q) |=> blk_q == $past(new_blk));
  p_ue_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n) ue_q |=> $stable(blk_q));
  p_ce_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n) (ce_q && !ue_valid) |=> $stable(blk_q));
  p_signal_r8: assert property (@(posedge clk) disable iff (!rst_n) ((ce_q && en_ce_q) || (ue_q && en_ue_q)) |-> err_signal);
  p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n) (!ce_q && !ue_q) |-> !err_signal);
endmodule

bind ecc_err_capture ecc_err_capture_chk #(.BLK_W(ADDR_W - PAGE_LSB)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_valid(ce_valid), .ue_valid(ue_valid),
  .new_blk(err_addr[ADDR_W-1:PAGE_LSB]), .reg_wr_en(reg_wr_en),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .ce_q(ce_q), .ue_q(ue_q),
  .en_ce_q(en_ce_q), .en_ue_q(en_ue_q), .blk_q(blk_q), .err_signal(err_signal)
);

// File: tb/test_ecc_err_capture.sv
module test_ecc_err_capture;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_valid = 1'b0, ue_valid = 1'b0, err_chan = 1'b0;
  logic [31:0] err_addr = '0;
  logic [7:0]  err_syn = '0;
  logic [2:0]  reg_addr = '0;
  logic        reg_wr_en = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        err_signal;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  ecc_err_capture i_ecc_err_capture (
    .clk(clk), .rst_n(rst_n), .ce_valid(ce_valid), .ue_valid(ue_valid),
    .err_addr(err_addr), .err_syn(err_syn), .err_chan(err_chan),
    .reg_addr(reg_addr), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .err_signal(err_signal)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
    @(negedge clk);
    reg_wr_en = 1'b0; reg_wdata = '0;
  endtask

  task automatic err(input logic ce, input logic ue, input logic [31:0] a,
                     input logic [7:0] s, input logic ch);
    @(negedge clk);
    ce_valid = ce; ue_valid = ue; err_addr = a; err_syn = s; err_chan = ch;
    @(negedge clk);
    ce_valid = 1'b0; ue_valid = 1'b0;
  endtask

  task automatic expect_record(input string req, input logic [31:0] a,
                               input logic [7:0] s, input logic ch);
    logic [31:0] d;
    rd(3'd2, d); check(req, d, a);
    rd(3'd3, d); check(req, d, {24'd0, s});
    rd(3'd4, d); check(req, d, {31'd0, ch});
  endtask

  task automatic t_reset;
    logic [31:0] d;
    for (int i = 0; i < 8; i++) begin
      rd(i[2:0], d); check("R1 reg", d, 32'd0);
    end
    check("R1 err_signal", {31'd0, err_signal}, 32'd0);
  endtask

  task automatic t_ce_capture;
    logic [31:0] d;
    err(1, 0, 32'h1234_5678, 8'hA5, 1);
    rd(3'd0, d); check("R2 ce flag", d, 32'h0001);
    expect_record("R3 capture", 32'h1234_5000, 8'hA5, 1);
    err(1, 0, 32'hDEAD_BEEF, 8'h11, 0);
    expect_record("R5 ce keeps ce record", 32'h1234_5000, 8'hA5, 1);
  endtask

  task automatic t_ue_override;
    logic [31:0] d;
    err(0, 1, 32'hCAFE_F00D, 8'h3C, 0);
    rd(3'd0, d); check("R2 both flags", d, 32'h0081);
    expect_record("R4 ue override", 32'hCAFE_F000, 8'h3C, 0);
    err(0, 1, 32'h1111_1111, 8'h77, 1);
    expect_record("R5 ue keeps ue record", 32'hCAFE_F000, 8'h3C, 0);
    err(1, 0, 32'h2222_2222, 8'h55, 1);
    expect_record("R5 ce keeps ue record", 32'hCAFE_F000, 8'h3C, 0);
  endtask

  task automatic t_w1c;
    logic [31:0] d;
    wr(3'd0, 32'h0000_0000);
    rd(3'd0, d); check("R6 zero write", d, 32'h0081);
    wr(3'd0, 32'h0000_0001);
    rd(3'd0, d); check("R6 clear ce", d, 32'h0080);
    wr(3'd0, 32'h0000_0080);
    rd(3'd0, d); check("R6 clear ue", d, 32'h0000);
    wr(3'd0, 32'hFFFF_FF7E);
    rd(3'd0, d); check("R9 reserved status", d, 32'h0000);
  endtask

  task automatic t_readonly;
    logic [31:0] d;
    wr(3'd2, 32'hFFFF_FFFF);
    wr(3'd3, 32'hFFFF_FFFF);
    wr(3'd4, 32'hFFFF_FFFF);
    expect_record("R9 read-only", 32'hCAFE_F000, 8'h3C, 0);
    wr(3'd6, 32'hFFFF_FFFF);
    rd(3'd6, d); check("R9 unused offset", d, 32'h0);
  endtask

  task automatic t_cmd;
    logic [31:0] d;
    wr(3'd1, 32'hFFFF_FFFF);
    rd(3'd1, d); check("R8 R9 cmd bits", d, 32'h0180);
    check("R8 no flag no signal", {31'd0, err_signal}, 32'd0);
    wr(3'd1, 32'h0000_0100);
    err(1, 0, 32'h0000_3000, 8'h01, 1);
    expect_record("R3 fresh ce", 32'h0000_3000, 8'h01, 1);
    check("R8 ce masked", {31'd0, err_signal}, 32'd0);
    wr(3'd1, 32'h0000_0080);
    check("R8 ce enabled", {31'd0, err_signal}, 32'd1);
    wr(3'd0, 32'h0000_0001);
    check("R8 drops on clear", {31'd0, err_signal}, 32'd0);
    wr(3'd1, 32'h0000_0100);
    err(0, 1, 32'h0000_5000, 8'h02, 0);
    check("R8 ue enabled", {31'd0, err_signal}, 32'd1);
    wr(3'd0, 32'h0000_0081);
    wr(3'd1, 32'h0);
  endtask

  task automatic t_collide;
    logic [31:0] d;
    err(1, 0, 32'h0000_7000, 8'h03, 0);
    @(negedge clk);
    ce_valid = 1'b1; reg_addr = 3'd0; reg_wdata = 32'h1; reg_wr_en = 1'b1;
    @(negedge clk);
    ce_valid = 1'b0; reg_wr_en = 1'b0;
    rd(3'd0, d); check("R7 error beats clear", d, 32'h0001);
    wr(3'd0, 32'h0000_0081);
  endtask

  task automatic t_simul;
    logic [31:0] d;
    rd(3'd0, d); check("R6 cleared", d, 32'h0000);
    err(1, 1, 32'hABCD_E123, 8'h9E, 1);
    rd(3'd0, d); check("R4 simultaneous flags", d, 32'h0081);
    expect_record("R4 simultaneous data", 32'hABCD_E000, 8'h9E, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_ce_capture;
    t_ue_override;
    t_w1c;
    t_readonly;
    t_cmd;
    t_collide;
    t_simul;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule